// File: doc/BRIEF.md
# Presettable Binary/Decade Up/Down Digit Counter

This block is a four-bit counter that runs either as a plain binary counter (0 to 15) or as a BCD decade digit (0 to 9). Both the radix and the direction can change at run time. Counting happens on the rising clock edge. It is gated by an active-low chain input, so that input works as a clock enable.

A parallel value can be forced into the counter at any time through a load-enable pin. This load does not wait for the clock, and no counting takes place while it is held. An active-low chain output is decoded combinationally from the visible count, the direction, the radix and the chain input. Wiring one digit's chain output to the next digit's chain input gives a look-ahead cascade in which every digit shares one clock.

Top module: `updown_digit_counter`

## Requirements
- R1: While `rst_n` is low, with `load_en` low, `count` reads 0 (encoding: `count` is the unsigned count value).
- R2: With `bin_mode`=1, `count_up`=1, `chain_in_n`=0 and `load_en`=0, each rising clock edge adds one to the count, and 15 is followed by 0.
- R3: With `bin_mode`=1, `count_up`=0 and counting enabled, each rising edge subtracts one, and 0 is followed by 15.
- R4: With `bin_mode`=0 (decade) and counting enabled, counting up goes from 9 to 0 and counting down goes from 0 to 9. From any count from 0 to 9, the next count is also from 0 to 9.
- R5: While `chain_in_n` is high, a clock edge leaves the count unchanged.
- R6: While `load_en` is high, `count` equals `load_val` without waiting for a clock edge, and clock edges do not advance it. After `load_en` falls, counting continues from the loaded value, provided `load_val` was held stable across at least one clock edge.
- R7: `chain_out_n` is low exactly when `chain_in_n` is low and either `count_up`=1 with the count at its top value (15 in binary, 9 in decade), or `count_up`=0 with the count at 0. It follows changes on `count_up`, `bin_mode` and `chain_in_n` without a clock edge.
- R8: In decade mode, a loaded count from 10 to 15 goes to 0 on the next up-count edge and to 9 on the next down-count edge. `chain_out_n` stays high at those counts.
- R9: Two digits connected chain-out to chain-in count 00 to 99 and back in decade mode, and 0 to 255 and back in binary mode, in both directions.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Counting clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| chain_in_n | input | 1 | Active-low count enable / cascade carry input |
| bin_mode | input | 1 | 1 selects binary modulus 16, 0 selects decade modulus 10 |
| count_up | input | 1 | 1 counts up, 0 counts down |
| load_en | input | 1 | High forces `load_val` into the counter asynchronously |
| load_val | input | 4 | Parallel value to load |
| count | output | 4 | Current count |
| chain_out_n | output | 1 | Active-low terminal-count / cascade carry output |

## Verification
The bound checker tests, on every clock edge, the single-step relations that hold no matter what came before. These are: binary increment and decrement by one, the decade wraps at 9 and 0, the decade range staying closed, an out-of-range decade code collapsing to 0 when counting up, the count holding while disabled, the count being visible during a load, and the chain output falling only when enabled and at a terminal value. Some behaviour only the bench scenarios can show. The chain output has to react to direction and radix changes between edges. The loaded value has to appear before any clock edge arrives. Two cascaded digits have to run through full 00..99 and 0..255 sequences in both directions with carries landing on the right edges.

// File: rtl/updown_cnt_pkg.sv
package updown_cnt_pkg;

  typedef enum logic {
    RADIX_DEC = 1'b0,
    RADIX_BIN = 1'b1
  } radix_e;

  typedef enum logic {
    DIR_DOWN = 1'b0,
    DIR_UP   = 1'b1
  } dir_e;

  localparam int unsigned DEC_TOP_VAL = 9;

endpackage

// File: rtl/cnt_rst_sync.sv
module cnt_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  generate
    if (STAGES == 1) begin : g_single
      always_comb sync_d = 1'b1;
    end else begin : g_chain
      always_comb sync_d = {sync_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_n_out = sync_q[STAGES-1];

endmodule

// File: rtl/cnt_step_logic.sv
module cnt_step_logic
  import updown_cnt_pkg::*;
#(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0] cur,
  input  radix_e       radix,
  input  dir_e         dir,
  output logic [W-1:0] nxt
);

  localparam logic [W-1:0] BIN_TOP = {W{1'b1}};
  localparam logic [W-1:0] DEC_TOP = W'(DEC_TOP_VAL);

  logic [W-1:0] top;

  always_comb begin
    top = (radix == RADIX_BIN) ? BIN_TOP : DEC_TOP;
    if (dir == DIR_UP) begin
      if (cur >= top) begin
        nxt = '0;
      end else begin
        nxt = cur + W'(1);
      end
    end else begin
      if (cur == '0) begin
        nxt = top;
      end else if (cur > top) begin
        nxt = top;
      end else begin
        nxt = cur - W'(1);
      end
    end
  end

endmodule

// File: rtl/cnt_term_decode.sv
module cnt_term_decode
  import updown_cnt_pkg::*;
#(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0] cur,
  input  radix_e       radix,
  input  dir_e         dir,
  input  logic         chain_in_n,
  output logic         chain_out_n
);

  localparam logic [W-1:0] BIN_TOP = {W{1'b1}};
  localparam logic [W-1:0] DEC_TOP = W'(DEC_TOP_VAL);

  logic at_top;
  logic at_zero;
  logic at_term;

  always_comb begin
    at_top  = (radix == RADIX_BIN) ? (cur == BIN_TOP) : (cur == DEC_TOP);
    at_zero = (cur == '0);
    at_term = (dir == DIR_UP) ? at_top : at_zero;
    chain_out_n = ~(at_term & ~chain_in_n);
  end

endmodule

// File: rtl/cnt_load_reg.sv
module cnt_load_reg #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_en,
  input  logic [W-1:0] load_val,
  input  logic         adv_en,
  input  logic [W-1:0] nxt,
  output logic [W-1:0] cnt_q
);

  always_ff @(posedge clk or negedge rst_n or posedge load_en) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load_en) begin
      cnt_q <= load_val;
    end else if (adv_en) begin
      cnt_q <= nxt;
    end
  end

endmodule

// File: rtl/updown_digit_counter.sv
module updown_digit_counter
  import updown_cnt_pkg::*;
#(
  parameter int unsigned W          = 4,
  parameter int unsigned RST_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         chain_in_n,
  input  logic         bin_mode,
  input  logic         count_up,
  input  logic         load_en,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] count,
  output logic         chain_out_n
);

  logic         rst_core_n;
  radix_e       radix;
  dir_e         dir;
  logic         adv_en;
  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_nxt;

  assign radix  = radix_e'(bin_mode);
  assign dir    = dir_e'(count_up);
  assign adv_en = ~chain_in_n & ~load_en;

  cnt_rst_sync #(.STAGES(RST_STAGES)) u_rst_sync (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_core_n)
  );

  cnt_step_logic #(.W(W)) u_step (
    .cur   (cnt_q),
    .radix (radix),
    .dir   (dir),
    .nxt   (cnt_nxt)
  );

  cnt_load_reg #(.W(W)) u_reg (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .load_en  (load_en),
    .load_val (load_val),
    .adv_en   (adv_en),
    .nxt      (cnt_nxt),
    .cnt_q    (cnt_q)
  );

  assign count = load_en ? load_val : cnt_q;

  cnt_term_decode #(.W(W)) u_term (
    .cur         (count),
    .radix       (radix),
    .dir         (dir),
    .chain_in_n  (chain_in_n),
    .chain_out_n (chain_out_n)
  );

endmodule

// File: rtl/updown_digit_counter_chk.sv
module updown_digit_counter_chk #(
  parameter int unsigned W = 4
) (
  input logic         clk,
  input logic         rst_core_n,
  input logic         chain_in_n,
  input logic         bin_mode,
  input logic         count_up,
  input logic         load_en,
  input logic [W-1:0] load_val,
  input logic [W-1:0] count,
  input logic         chain_out_n
);

  logic run;
  assign run = ~chain_in_n & ~load_en;

  AST_BIN_UP_STEP: assert property (@(posedge clk) disable iff (!rst_core_n)
    (run && bin_mode && count_up) |=> (load_en || count == W'($past(count) + 1))); // R2

  AST_BIN_DOWN_STEP: assert property (@(posedge clk) disable iff (!rst_core_n)
    (run && bin_mode && !count_up) |=> (load_en || count == W'($past(count) - 1))); // R3

  AST_DEC_UP_WRAP: assert property (@(posedge clk) disable iff (!rst_core_n)
    (run && !bin_mode && count_up && count == W'(9)) |=> (load_en || count == '0)); // R4

  AST_DEC_DOWN_WRAP: assert property (@(posedge clk) disable iff (!rst_core_n)
    (run && !bin_mode && !count_up && count == '0) |=> (load_en || count == W'(9))); // R4

  AST_DEC_STAYS_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_core_n)
    (run && !bin_mode && count <= W'(9)) |=> (load_en || count <= W'(9))); // R4

  AST_HOLD_WHEN_DISABLED: assert property (@(posedge clk) disable iff (!rst_core_n)
    (chain_in_n && !load_en) |=> (load_en || $stable(count))); // R5

  AST_LOAD_VISIBLE: assert property (@(posedge clk) disable iff (!rst_core_n)
    load_en |-> (count == load_val)); // R6

  AST_CHAIN_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_core_n)
    !chain_out_n |-> !chain_in_n); // R7

  AST_CHAIN_AT_TERMINAL: assert property (@(posedge clk) disable iff (!rst_core_n)
    !chain_out_n |-> (count == '0 || count == W'(9) || count == {W{1'b1}})); // R7

  AST_DEC_HIGH_COLLAPSE: assert property (@(posedge clk) disable iff (!rst_core_n)
    (run && !bin_mode && count_up && count > W'(9)) |=> (load_en || count == '0)); // R8

endmodule

bind updown_digit_counter updown_digit_counter_chk #(.W(W)) u_chk (
  .clk         (clk),
  .rst_core_n  (rst_core_n),
  .chain_in_n  (chain_in_n),
  .bin_mode    (bin_mode),
  .count_up    (count_up),
  .load_en     (load_en),
  .load_val    (load_val),
  .count       (count),
  .chain_out_n (chain_out_n)
);

// File: tb/tb_updown_digit_counter.sv
`timescale 1ns/1ps
module tb_updown_digit_counter;

  localparam int unsigned W = 4;
  localparam time PERIOD = 20ns;

  logic         clk;
  logic         rst_n;
  logic         chain_in_n;
  logic         bin_mode;
  logic         count_up;
  logic         load_en;
  logic [W-1:0] lo_val;
  logic [W-1:0] hi_val;
  logic [W-1:0] lo_cnt;
  logic [W-1:0] hi_cnt;
  logic         lo_co_n;
  logic         hi_co_n;

  int n_checks;
  int n_fails;
  bit done;

  typedef struct {
    logic [W-1:0] lo;
    logic [W-1:0] hi;
    logic         lo_co;
    logic         hi_co;
    string        tag;
  } exp_t;

  exp_t sb[$];

  logic [W-1:0] m_lo;
  logic [W-1:0] m_hi;

  updown_digit_counter #(.W(W)) dut (
    .clk(clk), .rst_n(rst_n), .chain_in_n(chain_in_n), .bin_mode(bin_mode),
    .count_up(count_up), .load_en(load_en), .load_val(lo_val),
    .count(lo_cnt), .chain_out_n(lo_co_n)
  );

  updown_digit_counter #(.W(W)) u_hi (
    .clk(clk), .rst_n(rst_n), .chain_in_n(lo_co_n), .bin_mode(bin_mode),
    .count_up(count_up), .load_en(load_en), .load_val(hi_val),
    .count(hi_cnt), .chain_out_n(hi_co_n)
  );

  initial clk = 1'b0;
  always #(PERIOD/2) clk = ~clk;

  function automatic logic [W-1:0] m_next(logic [W-1:0] v, logic b, logic u);
    logic [W-1:0] top;
    top = b ? 4'd15 : 4'd9;
    if (u) return (v >= top) ? 4'd0 : v + 4'd1;
    if (v == 4'd0) return top;
    if (v > top) return top;
    return v - 4'd1;
  endfunction

  function automatic logic m_term(logic [W-1:0] v, logic b, logic u);
    if (u) return v == (b ? 4'd15 : 4'd9);
    return v == 4'd0;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic m_lo_co();
    return !(!chain_in_n && m_term(m_lo, bin_mode, count_up));
  endfunction

  function automatic logic m_hi_co();
    return !(!m_lo_co() && m_term(m_hi, bin_mode, count_up));
  endfunction

  // driver: advance n clocks, pushing expected results into the scoreboard
  task automatic step(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      exp_t e;
      logic adv_hi;
      @(negedge clk);
      adv_hi = !chain_in_n && m_term(m_lo, bin_mode, count_up);
      if (!chain_in_n) m_lo = m_next(m_lo, bin_mode, count_up);
      if (adv_hi) m_hi = m_next(m_hi, bin_mode, count_up);
      e.lo = m_lo; e.hi = m_hi; e.lo_co = m_lo_co(); e.hi_co = m_hi_co(); e.tag = tag;
      sb.push_back(e);
      @(posedge clk);
      #3;
    end
  endtask

  // preset both digits: value visible before any clock, held through one edge
  task automatic preset(input logic [W-1:0] lv, input logic [W-1:0] hv);
    #2;
    lo_val = lv; hi_val = hv; load_en = 1'b1;
    #1;
    check(lo_cnt == lv, "R6 async load low digit", lo_cnt, lv);
    check(hi_cnt == hv, "R6 async load high digit", hi_cnt, hv);
    @(posedge clk);
    #3;
    check(lo_cnt == lv, "R6 no count while loading", lo_cnt, lv);
    load_en = 1'b0;
    m_lo = lv; m_hi = hv;
    #1;
    check(lo_cnt == lv, "R6 value kept after release", lo_cnt, lv);
  endtask

  // monitor: compare the design against the scoreboard after each edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        check(lo_cnt == e.lo, {e.tag, " low count"}, lo_cnt, e.lo);
        check(hi_cnt == e.hi, {e.tag, " high count"}, hi_cnt, e.hi);
        check(lo_co_n == e.lo_co, {e.tag, " R7 low chain out"}, lo_co_n, e.lo_co);
        check(hi_co_n == e.hi_co, {e.tag, " R7 high chain out"}, hi_co_n, e.hi_co);
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  endtask

  initial begin
    #(PERIOD * 200000);
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    n_checks = 0; n_fails = 0; done = 1'b0;
    rst_n = 1'b0; chain_in_n = 1'b1; bin_mode = 1'b1; count_up = 1'b1;
    load_en = 1'b0; lo_val = '0; hi_val = '0;
    m_lo = '0; m_hi = '0;
    repeat (3) @(posedge clk);
    #3;
    check(lo_cnt == 4'd0, "R1 reset low digit", lo_cnt, 0);
    check(hi_cnt == 4'd0, "R1 reset high digit", hi_cnt, 0);
    check(lo_co_n == 1'b1, "R7 chain out idle in reset", lo_co_n, 1);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #3;

    // binary up and down on the low digit
    chain_in_n = 1'b0; bin_mode = 1'b1; count_up = 1'b1;
    step(20, "R2");
    count_up = 1'b0;
    step(20, "R3");

    // hold
    chain_in_n = 1'b1;
    step(5, "R5");

    // decade
    chain_in_n = 1'b0; bin_mode = 1'b0; count_up = 1'b1;
    preset(4'd0, 4'd0);
    step(25, "R4");
    count_up = 1'b0;
    step(25, "R4");

    // load changes while held, then counting resumes from it
    chain_in_n = 1'b1; bin_mode = 1'b1; count_up = 1'b1;
    #2;
    lo_val = 4'd12; hi_val = 4'd0; load_en = 1'b1;
    #1;
    check(lo_cnt == 4'd12, "R6 first load value", lo_cnt, 12);
    lo_val = 4'd5;
    #1;
    check(lo_cnt == 4'd5, "R6 load follows value", lo_cnt, 5);
    @(posedge clk);
    #3;
    load_en = 1'b0;
    m_lo = 4'd5; m_hi = 4'd0;
    chain_in_n = 1'b0;
    step(3, "R6");

    // out-of-range decade codes
    bin_mode = 1'b0; count_up = 1'b1;
    preset(4'd12, 4'd0);
    check(lo_co_n == 1'b1, "R8 no carry at 12", lo_co_n, 1);
    step(1, "R8");
    check(lo_cnt == 4'd0, "R8 12 up goes to 0", lo_cnt, 0);
    count_up = 1'b0;
    preset(4'd14, 4'd0);
    check(lo_co_n == 1'b1, "R8 no borrow at 14", lo_co_n, 1);
    step(1, "R8");
    check(lo_cnt == 4'd9, "R8 14 down goes to 9", lo_cnt, 9);

    // chain output reacts without a clock
    count_up = 1'b1; chain_in_n = 1'b1;
    preset(4'd9, 4'd0);
    chain_in_n = 1'b0;
    #1;
    check(lo_co_n == 1'b0, "R7 decade up at 9", lo_co_n, 0);
    count_up = 1'b0;
    #1;
    check(lo_co_n == 1'b1, "R7 direction flip clears", lo_co_n, 1);
    count_up = 1'b1; bin_mode = 1'b1;
    #1;
    check(lo_co_n == 1'b1, "R7 binary at 9 not terminal", lo_co_n, 1);
    bin_mode = 1'b0; chain_in_n = 1'b1;
    #1;
    check(lo_co_n == 1'b1, "R7 disabled clears", lo_co_n, 1);
    chain_in_n = 1'b0;
    #1;
    check(lo_co_n == 1'b0, "R7 enabled again", lo_co_n, 0);
    step(1, "R4");

    // two-digit cascade
    chain_in_n = 1'b1; bin_mode = 1'b0; count_up = 1'b1;
    preset(4'd0, 4'd0);
    chain_in_n = 1'b0;
    step(100, "R9");
    check(lo_cnt == 4'd0 && hi_cnt == 4'd0, "R9 decade 99 wraps to 00", {hi_cnt, lo_cnt}, 0);
    count_up = 1'b0;
    step(100, "R9");
    bin_mode = 1'b1; count_up = 1'b1;
    step(256, "R9");
    check(lo_cnt == 4'd0 && hi_cnt == 4'd0, "R9 binary 255 wraps to 0", {hi_cnt, lo_cnt}, 0);
    count_up = 1'b0;
    step(256, "R9");

    repeat (2) @(posedge clk);
    #3;
    finish_run();
  end

endmodule